// File: doc/BRIEF.md
# March-Pattern Memory Self-Test Controller

This block is a built-in self-test sequencer for a synchronous single-port RAM of 2^ADDR_W one-bit words. A single start pulse makes it apply a fixed march algorithm. It first clears every cell while walking upward. It then climbs the array again, checking that each cell still holds the cleared value, setting it, and confirming the new value. Finally it walks downward doing the mirror image of that element. The entire sequence is then repeated with every data value inverted. The controller issues exactly one memory operation per clock, for 14·N operations in total.

Each read result returns one cycle after the read is issued. It is compared against the bit the algorithm predicts for that read. The first mismatch is kept: the cell address, the bit that was expected, and a code that names the pass and polarity. Testing normally continues to the end of the algorithm. When the stop-on-fail input is high, the controller instead stops at the first mismatch. In both cases it signals completion with a one-cycle done pulse and then goes back to idle.

Top module: `march_bist`

## Requirements
- R1: After reset the controller is idle: `done_o` and `fail_o` are low and neither `mem_we_o` nor `mem_re_o` is asserted until a start is accepted.
- R2: `start_i` is accepted only while idle. A start seen during a run has no effect on the sequence or on its length.
- R3: The initialising pass writes the current polarity bit (0 in the first run, 1 in the second) to every address from 0 up to N-1, one write per cycle.
- R4: The ascending pass visits addresses 0 up to N-1. At each address it issues, on consecutive cycles, a read expecting the polarity bit, a write of its complement, and a read expecting that complement.
- R5: The descending pass visits addresses N-1 down to 0. At each address it issues a read expecting the complemented polarity, a write of the polarity bit, and a read expecting the polarity bit.
- R6: After the descending pass of the first run, the three passes repeat with polarity 1, giving 14·N memory operations back to back with no idle cycle between them.
- R7: Read data on `mem_rdata_i` is compared one cycle after its read was issued. A mismatch sets `fail_o` on the following edge, so `fail_o` is first visible k+2 cycles after the start edge for a failing operation with index k.
- R8: The first mismatch latches `err_addr_o`, `err_exp_o` and `err_phase_o`. Bit 2 of `err_phase_o` is the polarity, and bits 1:0 encode the pass: 1 = initialise, 2 = ascending, 3 = descending. These fields and `fail_o` keep their values through later mismatches and are cleared only when the next start is accepted.
- R9: Without an early stop, `done_o` is high for exactly one cycle, first visible 14·N+1 cycles after the edge that accepted start. The controller then stays idle with no memory operations.
- R10: When `stop_on_fail_i` is high, the first mismatch ends the run. `done_o` becomes visible in the same cycle as `fail_o` (k+2 cycles after the start edge), and the latched error refers to that first mismatch.
- R11: `mem_we_o` and `mem_re_o` are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a test run (taken only when idle) |
| stop_on_fail_i | input | 1 | End the run at the first mismatch |
| mem_addr_o | output | ADDR_W | RAM address |
| mem_we_o | output | 1 | RAM write enable |
| mem_wdata_o | output | 1 | RAM write data |
| mem_re_o | output | 1 | RAM read enable |
| mem_rdata_i | input | 1 | RAM read data, valid one cycle after the read |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Sticky mismatch flag |
| err_addr_o | output | ADDR_W | Address of the first mismatch |
| err_exp_o | output | 1 | Expected bit at the first mismatch |
| err_phase_o | output | 3 | Polarity (bit 2) and pass (bits 1:0) of the first mismatch |

## Verification
The bench builds the controller with ADDR_W = 3, so each run is 112 operations. That makes it practical to compare every issued operation against an independently computed march sequence, covering both polarities and both walking directions. The small array also puts the wrap points of the address counter (top at 7, bottom at 0) within a few cycles of one another. Exact cycle counts for done and fail can then be predicted for stuck-at cells, a blocked falling transition found only by the descending pass, an early stop, and a start pulse arriving mid-run.

// File: rtl/march_bist_pkg.sv
package march_bist_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_DRAIN = 2'd2,
      ST_DONE  = 2'd3
   } ctl_st_e;

   // pass code reported in bits 1:0 of the error phase field
   typedef enum logic [1:0] {
      PASS_INIT = 2'd1,
      PASS_UP   = 2'd2,
      PASS_DOWN = 2'd3
   } pass_e;

   // position inside a read-write-read element
   typedef enum logic [1:0] {
      SLOT_RD_A = 2'd0,
      SLOT_WR   = 2'd1,
      SLOT_RD_B = 2'd2
   } slot_e;

   localparam int PHASE_W = 3;

endpackage

// File: rtl/march_addr_ctr.sv
module march_addr_ctr #(
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          hi_i,
   input  logic          inc_i,
   input  logic          dec_i,
   output logic [AW-1:0] addr_o,
   output logic          top_o,
   output logic          bot_o
);
   localparam logic [AW-1:0] TOP = {AW{1'b1}};
   localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_o <= '0;
      else if (clr_i)  addr_o <= '0;
      else if (hi_i)   addr_o <= TOP;
      else if (inc_i)  addr_o <= addr_o + ONE;
      else if (dec_i)  addr_o <= addr_o - ONE;
   end

   assign top_o = (addr_o == TOP);
   assign bot_o = (addr_o == '0);
endmodule

// File: rtl/march_seq.sv
module march_seq
   import march_bist_pkg::*;
#(
   parameter int AW = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               abort_i,
   output logic [AW-1:0]      addr_o,
   output logic               we_o,
   output logic               re_o,
   output logic               bit_o,
   output logic [PHASE_W-1:0] phase_o,
   output logic               done_o,
   output logic               clear_o
);
   ctl_st_e st_q;
   pass_e   pass_q;
   slot_e   slot_q;
   logic    pol_q;
   logic    run;
   logic    elem_end;
   logic    c_clr, c_hi, c_inc, c_dec;
   logic    top, bot;

   march_addr_ctr #(.AW(AW)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (c_clr),
      .hi_i   (c_hi),
      .inc_i  (c_inc),
      .dec_i  (c_dec),
      .addr_o (addr_o),
      .top_o  (top),
      .bot_o  (bot)
   );

   assign run      = (st_q == ST_RUN);
   assign elem_end = (pass_q == PASS_INIT) || (slot_q == SLOT_RD_B);
   assign we_o     = run && ((pass_q == PASS_INIT) || (slot_q == SLOT_WR));
   assign re_o     = run && (pass_q != PASS_INIT) && (slot_q != SLOT_WR);
   assign phase_o  = {pol_q, pass_q};
   assign done_o   = (st_q == ST_DONE);
   assign clear_o  = (st_q == ST_IDLE) && start_i;

   // data bit for writes and expected bit for reads
   always_comb begin
      unique case (pass_q)
         PASS_UP:   bit_o = (slot_q == SLOT_RD_A) ? pol_q : ~pol_q;
         PASS_DOWN: bit_o = (slot_q == SLOT_RD_A) ? ~pol_q : pol_q;
         default:   bit_o = pol_q;
      endcase
   end

   // address counter steering
   always_comb begin
      c_clr = clear_o;
      c_hi  = 1'b0;
      c_inc = 1'b0;
      c_dec = 1'b0;
      if (run && !abort_i && elem_end) begin
         unique case (pass_q)
            PASS_INIT: if (top) c_clr = 1'b1; else c_inc = 1'b1;
            PASS_UP:   if (top) c_hi  = 1'b1; else c_inc = 1'b1;
            default:   if (bot) c_clr = 1'b1; else c_dec = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         pass_q <= PASS_INIT;
         slot_q <= SLOT_RD_A;
         pol_q  <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (start_i) begin
               st_q   <= ST_RUN;
               pass_q <= PASS_INIT;
               slot_q <= SLOT_RD_A;
               pol_q  <= 1'b0;
            end
            ST_RUN: begin
               if (abort_i) begin
                  st_q <= ST_DONE;
               end else if (!elem_end) begin
                  slot_q <= (slot_q == SLOT_RD_A) ? SLOT_WR : SLOT_RD_B;
               end else begin
                  slot_q <= SLOT_RD_A;
                  unique case (pass_q)
                     PASS_INIT: if (top) pass_q <= PASS_UP;
                     PASS_UP:   if (top) pass_q <= PASS_DOWN;
                     default: if (bot) begin
                        if (!pol_q) begin
                           pol_q  <= 1'b1;
                           pass_q <= PASS_INIT;
                        end else begin
                           st_q <= ST_DRAIN;
                        end
                     end
                  endcase
               end
            end
            ST_DRAIN: st_q <= ST_DONE;
            default:  st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/march_resp.sv
module march_resp
   import march_bist_pkg::*;
#(
   parameter int AW = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear_i,
   input  logic               rd_i,
   input  logic               exp_i,
   input  logic [AW-1:0]      addr_i,
   input  logic [PHASE_W-1:0] phase_i,
   input  logic               rdata_i,
   output logic               mismatch_o,
   output logic               fail_o,
   output logic [AW-1:0]      err_addr_o,
   output logic               err_exp_o,
   output logic [PHASE_W-1:0] err_phase_o
);
   logic               pend_v;
   logic               pend_exp;
   logic [AW-1:0]      pend_addr;
   logic [PHASE_W-1:0] pend_phase;

   // one stage matching the RAM read latency
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v     <= 1'b0;
         pend_exp   <= 1'b0;
         pend_addr  <= '0;
         pend_phase <= '0;
      end else begin
         pend_v     <= rd_i;
         pend_exp   <= exp_i;
         pend_addr  <= addr_i;
         pend_phase <= phase_i;
      end
   end

   assign mismatch_o = pend_v && (rdata_i != pend_exp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fail_o      <= 1'b0;
         err_addr_o  <= '0;
         err_exp_o   <= 1'b0;
         err_phase_o <= '0;
      end else if (clear_i) begin
         fail_o      <= 1'b0;
         err_addr_o  <= '0;
         err_exp_o   <= 1'b0;
         err_phase_o <= '0;
      end else if (mismatch_o && !fail_o) begin
         fail_o      <= 1'b1;
         err_addr_o  <= pend_addr;
         err_exp_o   <= pend_exp;
         err_phase_o <= pend_phase;
      end
   end
endmodule

// File: rtl/march_bist.sv
module march_bist
   import march_bist_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                stop_on_fail_i,
   output logic [ADDR_W-1:0]   mem_addr_o,
   output logic                mem_we_o,
   output logic                mem_wdata_o,
   output logic                mem_re_o,
   input  logic                mem_rdata_i,
   output logic                done_o,
   output logic                fail_o,
   output logic [ADDR_W-1:0]   err_addr_o,
   output logic                err_exp_o,
   output logic [PHASE_W-1:0]  err_phase_o
);
   localparam int MAX_AW = 24;

   if (ADDR_W < 1) begin : g_aw_low
      $error("march_bist: ADDR_W must be at least 1");
   end
   if (ADDR_W > MAX_AW) begin : g_aw_high
      $error("march_bist: ADDR_W exceeds supported maximum");
   end

   logic               bit_w;
   logic [PHASE_W-1:0] phase_w;
   logic               clear_w;
   logic               mismatch_w;

   march_seq #(.AW(ADDR_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .abort_i (mismatch_w && stop_on_fail_i),
      .addr_o  (mem_addr_o),
      .we_o    (mem_we_o),
      .re_o    (mem_re_o),
      .bit_o   (bit_w),
      .phase_o (phase_w),
      .done_o  (done_o),
      .clear_o (clear_w)
   );

   assign mem_wdata_o = bit_w;

   march_resp #(.AW(ADDR_W)) u_resp (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (clear_w),
      .rd_i        (mem_re_o),
      .exp_i       (bit_w),
      .addr_i      (mem_addr_o),
      .phase_i     (phase_w),
      .rdata_i     (mem_rdata_i),
      .mismatch_o  (mismatch_w),
      .fail_o      (fail_o),
      .err_addr_o  (err_addr_o),
      .err_exp_o   (err_exp_o),
      .err_phase_o (err_phase_o)
   );
endmodule

// File: rtl/march_bist_chk.sv
module march_bist_chk
   import march_bist_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start_i,
   input logic               stop_on_fail_i,
   input logic [ADDR_W-1:0]  mem_addr_o,
   input logic               mem_we_o,
   input logic               mem_wdata_o,
   input logic               mem_re_o,
   input logic               mem_rdata_i,
   input logic               done_o,
   input logic               fail_o,
   input logic [ADDR_W-1:0]  err_addr_o,
   input logic               err_exp_o,
   input logic [PHASE_W-1:0] err_phase_o
);
   AST_SINGLE_OP: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we_o && mem_re_o)); // R11

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R9

   AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!mem_we_o && !mem_re_o)); // R9

   AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_o && !start_i) |=> fail_o); // R8

   AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_o && !start_i) |=> ($stable(err_addr_o) && $stable(err_exp_o)
                                && $stable(err_phase_o))); // R8

   AST_FAIL_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail_o) |-> $past(mem_re_o, 2)); // R7

   AST_PHASE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o |-> (err_phase_o[1:0] != 2'd0)); // R8
endmodule

bind march_bist march_bist_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_march_bist.sv
module tb_march_bist;
   localparam int AW    = 3;
   localparam int N     = 1 << AW;
   localparam int TOTAL = 14 * N;
   localparam int LIMIT = 1000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          stop_on_fail_i = 1'b0;
   logic [AW-1:0] mem_addr_o;
   logic          mem_we_o, mem_wdata_o, mem_re_o;
   logic          mem_rdata_i;
   logic          done_o, fail_o, err_exp_o;
   logic [AW-1:0] err_addr_o;
   logic [2:0]    err_phase_o;

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   march_bist #(.ADDR_W(AW)) dut (.*);

   // behavioural RAM with fault injection
   logic         ram [N];
   logic [N-1:0] sa0 = '0, sa1 = '0, no_fall = '0;
   logic         wipe = 1'b0;

   always_ff @(posedge clk) begin
      if (wipe) begin
         for (int i = 0; i < N; i++) ram[i] <= 1'b0;
      end else begin
         if (mem_re_o)
            mem_rdata_i <= sa0[mem_addr_o] ? 1'b0 :
                           sa1[mem_addr_o] ? 1'b1 : ram[mem_addr_o];
         if (mem_we_o && !(no_fall[mem_addr_o] && ram[mem_addr_o] && !mem_wdata_o))
            ram[mem_addr_o] <= mem_wdata_o;
      end
   end

   // expected operation k of the march sequence: {we, re, addr, bit}
   function automatic logic [AW+2:0] exp_op(int k);
      int r, q;
      logic pol;
      logic [AW-1:0] a;
      pol = (k >= 7 * N);
      r = k % (7 * N);
      if (r < N) return {2'b10, AW'(r), pol};
      if (r < 4 * N) begin
         q = r - N;
         a = AW'(q / 3);
         case (q % 3)
            0: return {2'b01, a, pol};
            1: return {2'b10, a, ~pol};
            default: return {2'b01, a, ~pol};
         endcase
      end
      q = r - 4 * N;
      a = AW'(N - 1 - q / 3);
      case (q % 3)
         0: return {2'b01, a, ~pol};
         1: return {2'b10, a, pol};
         default: return {2'b01, a, pol};
      endcase
   endfunction

   function automatic int exp_region(int k);
      int r;
      if (k >= 7 * N) return 3;
      r = k % (7 * N);
      if (r < N) return 0;
      if (r < 4 * N) return 1;
      return 2;
   endfunction

   // operation trace monitor, sampled away from the active edge
   int   op_cnt = 0;
   int   both_cnt = 0;
   int   bad [4] = '{0, 0, 0, 0};
   logic trace_on = 1'b0;
   int   tbase = 0;

   always @(negedge clk) begin
      if (mem_we_o && mem_re_o) both_cnt++;
      if (trace_on && (mem_we_o || mem_re_o)) begin
         if (op_cnt - tbase < TOTAL) begin
            logic [AW+2:0] e;
            e = exp_op(op_cnt - tbase);
            if ({mem_we_o, mem_re_o, mem_addr_o} != e[AW+2:1] ||
                (mem_we_o && mem_wdata_o != e[0]))
               bad[exp_region(op_cnt - tbase)]++;
         end
         op_cnt++;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // run one test: returns cycles to done and to first fail
   task automatic run(input logic stop, input int mid_start,
                      output int n_done, output int n_fail);
      int n;
      @(negedge clk);
      stop_on_fail_i = stop;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      n = 0;
      n_fail = -1;
      while (!done_o && n < LIMIT) begin
         if (fail_o && n_fail < 0) n_fail = n;
         start_i = (n == mid_start);
         @(negedge clk);
         n++;
      end
      start_i = 1'b0;
      if (fail_o && n_fail < 0) n_fail = n;
      n_done = n;
   endtask

   task automatic clear_faults();
      sa0 = '0; sa1 = '0; no_fall = '0;
      @(negedge clk); wipe = 1'b1;
      @(negedge clk); wipe = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 done after reset", done_o, 0);
      chk("R1 fail after reset", fail_o, 0);
      chk("R1 no op after reset", mem_we_o | mem_re_o, 0);
      repeat (3) @(negedge clk);
      chk("R1 still idle", mem_we_o | mem_re_o, 0);
   endtask

   task automatic t_clean();
      int nd, nf, b0, b1, b2, b3, ops, busy;
      clear_faults();
      b0 = bad[0]; b1 = bad[1]; b2 = bad[2]; b3 = bad[3];
      tbase = op_cnt;
      trace_on = 1'b1;
      run(1'b0, -1, nd, nf);
      trace_on = 1'b0;
      ops = op_cnt - tbase;
      chk("R9 done cycle", nd, TOTAL + 1);
      chk("R7 no fail on good RAM", fail_o, 0);
      chk("R3 init pass ops", bad[0] - b0, 0);
      chk("R4 ascending pass ops", bad[1] - b1, 0);
      chk("R5 descending pass ops", bad[2] - b2, 0);
      chk("R6 complemented run ops", bad[3] - b3, 0);
      chk("R6 op count", ops, TOTAL);
      @(negedge clk);
      chk("R9 done single cycle", done_o, 0);
      busy = 0;
      for (int i = 0; i < 6; i++) begin
         busy += (mem_we_o | mem_re_o);
         @(negedge clk);
      end
      chk("R9 idle after done", busy, 0);
      chk("R11 no combined op", both_cnt, 0);
   endtask

   task automatic t_stuck();
      int nd, nf;
      clear_faults();
      sa0[5] = 1'b1;
      sa1[2] = 1'b1;
      run(1'b0, -1, nd, nf);
      chk("R10 no stop runs full", nd, TOTAL + 1);
      chk("R7 fail timing", nf, 16);
      chk("R8 first err addr", err_addr_o, 2);
      chk("R8 first err exp", err_exp_o, 0);
      chk("R8 first err phase", err_phase_o, 3'b010);
   endtask

   task automatic t_fall();
      int nd, nf;
      clear_faults();
      no_fall[3] = 1'b1;
      run(1'b0, -1, nd, nf);
      chk("R5 fall fault fail", fail_o, 1);
      chk("R5 fall fault addr", err_addr_o, 3);
      chk("R5 fall fault exp", err_exp_o, 0);
      chk("R8 fall fault phase", err_phase_o, 3'b011);
   endtask

   task automatic t_stop();
      int nd, nf;
      clear_faults();
      sa0[5] = 1'b1;
      run(1'b1, -1, nd, nf);
      chk("R10 early done", nd, 27);
      chk("R10 fail with done", nf, 27);
      chk("R10 err addr", err_addr_o, 5);
      chk("R10 err exp", err_exp_o, 1);
      chk("R10 err phase", err_phase_o, 3'b010);
   endtask

   task automatic t_restart();
      int nd, nf;
      clear_faults();
      run(1'b0, 20, nd, nf);
      chk("R2 mid-run start ignored", nd, TOTAL + 1);
      chk("R8 fail cleared on start", fail_o, 0);
      chk("R8 err addr cleared", err_addr_o, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_clean();
      t_stuck();
      t_fall();
      t_stop();
      t_restart();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule